// File: doc/BRIEF.md
# SMI and SCI Interrupt Generator

This block gathers system-management event requests and turns them into two interrupt outputs. The first is an active-low system-management interrupt line to the processor. The second is a level-mode system-control interrupt for an ACPI-style handler, steered onto one of three legacy IRQ lines.

Each event source has a sticky status bit, an enable bit and a routing bit. The routing bit sends the event to the SMI path or to the SCI path, never to both. Software clears status bits with write-one-to-clear strobes.

Once the SMI line is asserted, it stays asserted until software writes the end-of-SMI bit. The line is then held high for a guaranteed minimum number of clocks. After that gap, any event that is still pending asserts it again. The SCI output follows its enabled status bits as a level. A small routing register, which resets to IRQ 9, selects the IRQ line that carries it.

Top module: `smi_sci_gen`

## Requirements
- R1: Whenever an event status bit is set with its enable at 1 and its routing bit at 0 (SMI), `smi_n` goes low on the clock after the status bit reads 1, unless the line is in its post-EOS gap.
- R2: Once low, `smi_n` stays low until the EOS bit reads 1. It goes high on the next clock, and the EOS bit reads 0 on that same clock.
- R3: After EOS releases it, `smi_n` stays high for at least GAP_CYC (default 4) consecutive clocks, even while SMI events are pending.
- R4: Events that arrive during the gap are held in status. If an enabled SMI event is pending when the gap ends, `smi_n` goes low on the clock directly after the last gap clock.
- R5: A pulse on `eos_set` while `smi_n` is high leaves the EOS bit at 0.
- R6: Status bits are sticky. A `sts_clr` bit clears its status bit on the next clock. An event pulse in the same cycle wins over the clear, and the bit stays 1.
- R7: `sci_irq` is non-zero exactly while some status bit is set with its enable at 1 and its routing bit at 1 (SCI). Disabled events drive nothing.
- R8: `sci_irq` is one-hot when active: bit 0 = IRQ 9, bit 1 = IRQ 10, bit 2 = IRQ 11. A `cfg_wr` pulse loads `cfg_irq` codes 0/1/2 (IRQ 9/10/11), and code 3 is ignored.
- R9: An event with routing bit 1 never drives `smi_n` low. An event with routing bit 0 never drives `sci_irq`.
- R10: Reset leaves `smi_n` high, `sci_irq` at 0, all status bits at 0, the EOS bit at 0 and routing at IRQ 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | N_EVT | Event request strobes, one per source |
| evt_en | input | N_EVT | Per-event enable |
| evt_route | input | N_EVT | Per-event path select: 0 = SMI, 1 = SCI |
| sts_clr | input | N_EVT | Write-one-to-clear strobes for status |
| eos_set | input | 1 | Software write of 1 to the EOS bit |
| cfg_wr | input | 1 | Load strobe for the IRQ routing register |
| cfg_irq | input | 2 | Routing code: 0 = IRQ 9, 1 = IRQ 10, 2 = IRQ 11 |
| smi_n | output | 1 | Active-low SMI to the processor |
| sci_irq | output | 3 | SCI level on IRQ 9 / 10 / 11 (bit 0 / 1 / 2) |
| evt_sts | output | N_EVT | Sticky event status |
| eos_bit | output | 1 | Current EOS bit value |

## Verification
The assertions assume that `evt_en` and `evt_route` are stable whenever an enabled status bit is set. Under that assumption, a pending SMI event stays pending until software clears it, and the bound on how long pending SMI work may wait with the line high can be checked. The random phase keeps within this by changing enables and routing only while all status is clear. Event, clear, EOS and routing strobes are drawn freely from `$urandom`. Directed cases cover EOS written while idle, a set and a clear in the same cycle, the gap length with work pending, and the ignored routing code.

// File: rtl/smi_sci_pkg.sv
package smi_sci_pkg;

  typedef enum logic [1:0] {
    SMI_IDLE   = 2'd0,
    SMI_ACTIVE = 2'd1,
    SMI_GAP    = 2'd2
  } smi_state_e;

  localparam logic [1:0] IRQ_CODE_9   = 2'd0;
  localparam logic [1:0] IRQ_CODE_10  = 2'd1;
  localparam logic [1:0] IRQ_CODE_11  = 2'd2;
  localparam logic [1:0] IRQ_CODE_BAD = 2'd3;
  localparam int unsigned IRQ_LINES   = 3;

  function automatic logic [IRQ_LINES-1:0] irq_onehot(input logic [1:0] code);
    logic [IRQ_LINES-1:0] v;
    v = '0;
    for (int k = 0; k < IRQ_LINES; k++) begin
      if (code == k[1:0]) v[k] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/smi_evt_status.sv
module smi_evt_status #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic [N_EVT-1:0] sts_clr,
  input  logic [N_EVT-1:0] evt_en,
  input  logic [N_EVT-1:0] evt_route,
  output logic [N_EVT-1:0] sts_q,
  output logic             smi_pend,
  output logic             sci_pend
);

  logic [N_EVT-1:0] sts_d;

  for (genvar g = 0; g < N_EVT; g++) begin : g_bit
    always_comb begin
      sts_d[g] = sts_q[g];
      if (sts_clr[g])   sts_d[g] = 1'b0;
      if (evt_pulse[g]) sts_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[g] <= 1'b0;
      else        sts_q[g] <= sts_d[g];
    end
  end

  assign smi_pend = |(sts_q & evt_en & ~evt_route);
  assign sci_pend = |(sts_q & evt_en &  evt_route);

endmodule

// File: rtl/smi_assert_ctrl.sv
module smi_assert_ctrl
  import smi_sci_pkg::*;
#(
  parameter int unsigned GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_pend,
  input  logic eos_set,
  output logic smi_n,
  output logic eos_q
);

  localparam int unsigned CNT_W = $clog2(GAP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYC);

  smi_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             eos_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    eos_d   = eos_q;
    unique case (state_q)
      SMI_IDLE: begin
        if (smi_pend) state_d = SMI_ACTIVE;
      end
      SMI_ACTIVE: begin
        if (eos_q) begin
          state_d = SMI_GAP;
          eos_d   = 1'b0;
          cnt_d   = CNT_ONE;
          cnt_en  = 1'b1;
        end else if (eos_set) begin
          eos_d = 1'b1;
        end
      end
      SMI_GAP: begin
        if (cnt_q == CNT_LAST) begin
          state_d = smi_pend ? SMI_ACTIVE : SMI_IDLE;
        end else begin
          cnt_d  = cnt_q + CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      default: state_d = SMI_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SMI_IDLE;
      eos_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      eos_q   <= eos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign smi_n = (state_q != SMI_ACTIVE);

endmodule

// File: rtl/sci_irq_route.sv
module sci_irq_route
  import smi_sci_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_irq,
  input  logic                 sci_pend,
  output logic [IRQ_LINES-1:0] sci_irq
);

  logic [1:0] route_q;
  logic       route_ld;

  assign route_ld = cfg_wr && (cfg_irq != IRQ_CODE_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        route_q <= IRQ_CODE_9;
    else if (route_ld) route_q <= cfg_irq;
  end

  assign sci_irq = sci_pend ? irq_onehot(route_q) : '0;

endmodule

// File: rtl/smi_sci_gen.sv
module smi_sci_gen
  import smi_sci_pkg::*;
#(
  parameter int unsigned N_EVT   = 8,
  parameter int unsigned GAP_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic [N_EVT-1:0] evt_en,
  input  logic [N_EVT-1:0] evt_route,
  input  logic [N_EVT-1:0] sts_clr,
  input  logic             eos_set,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_irq,
  output logic             smi_n,
  output logic [2:0]       sci_irq,
  output logic [N_EVT-1:0] evt_sts,
  output logic             eos_bit
);

  logic smi_pend;
  logic sci_pend;

  smi_evt_status #(.N_EVT(N_EVT)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .sts_clr   (sts_clr),
    .evt_en    (evt_en),
    .evt_route (evt_route),
    .sts_q     (evt_sts),
    .smi_pend  (smi_pend),
    .sci_pend  (sci_pend)
  );

  smi_assert_ctrl #(.GAP_CYC(GAP_CYC)) u_smi (
    .clk      (clk),
    .rst_n    (rst_n),
    .smi_pend (smi_pend),
    .eos_set  (eos_set),
    .smi_n    (smi_n),
    .eos_q    (eos_bit)
  );

  sci_irq_route u_sci (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_irq  (cfg_irq),
    .sci_pend (sci_pend),
    .sci_irq  (sci_irq)
  );

endmodule

// File: rtl/smi_sci_gen_chk.sv
module smi_sci_gen_chk #(
  parameter int unsigned N_EVT   = 8,
  parameter int unsigned GAP_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_en,
  input logic [N_EVT-1:0] evt_route,
  input logic [N_EVT-1:0] sts_clr,
  input logic             smi_n,
  input logic [2:0]       sci_irq,
  input logic [N_EVT-1:0] evt_sts,
  input logic             eos_bit
);

  localparam int unsigned W = $clog2(GAP_CYC + 3);

  logic         seen_low;
  logic [W-1:0] hi_run;
  logic [W-1:0] pend_hi;
  logic         smi_work;

  assign smi_work = |(evt_sts & evt_en & ~evt_route);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_low <= 1'b0;
      hi_run   <= '0;
      pend_hi  <= '0;
    end else begin
      if (!smi_n) seen_low <= 1'b1;
      if (!smi_n) hi_run <= '0;
      else if (hi_run != W'(GAP_CYC + 1)) hi_run <= hi_run + W'(1);
      if (!smi_n || !smi_work) pend_hi <= '0;
      else if (pend_hi != W'(GAP_CYC + 1)) pend_hi <= pend_hi + W'(1);
    end
  end

  assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!smi_n && !eos_bit) |=> !smi_n);

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!smi_n && eos_bit) |=> (smi_n && !eos_bit));

  assert_min_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(smi_n) && seen_low) |-> (hi_run >= W'(GAP_CYC)));

  assert_no_starve_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_hi <= W'(GAP_CYC));

  assert_eos_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_bit) |-> !smi_n);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_sts & $past(evt_sts & ~sts_clr)) == $past(evt_sts & ~sts_clr)));

  assert_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sci_irq != 3'b000) == (|(evt_sts & evt_en & evt_route))));

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sci_irq));

endmodule

bind smi_sci_gen smi_sci_gen_chk #(.N_EVT(N_EVT), .GAP_CYC(GAP_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_en    (evt_en),
  .evt_route (evt_route),
  .sts_clr   (sts_clr),
  .smi_n     (smi_n),
  .sci_irq   (sci_irq),
  .evt_sts   (evt_sts),
  .eos_bit   (eos_bit)
);

// File: tb/tb_smi_sci_gen.sv
`timescale 1ns/1ps
module tb_smi_sci_gen;

  localparam int N   = 8;
  localparam int GAP = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_pulse = '0, evt_en = '0, evt_route = '0, sts_clr = '0;
  logic         eos_set = 1'b0, cfg_wr = 1'b0;
  logic [1:0]   cfg_irq = 2'd0;
  logic         smi_n;
  logic [2:0]   sci_irq;
  logic [N-1:0] evt_sts;
  logic         eos_bit;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state
  logic [N-1:0] m_sts;
  int           m_st;    // 0 idle, 1 active, 2 gap
  int           m_cnt;
  logic         m_eos;
  logic [1:0]   m_route;

  always #2 clk = ~clk;

  smi_sci_gen #(.N_EVT(N), .GAP_CYC(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_en(evt_en),
    .evt_route(evt_route), .sts_clr(sts_clr), .eos_set(eos_set),
    .cfg_wr(cfg_wr), .cfg_irq(cfg_irq), .smi_n(smi_n), .sci_irq(sci_irq),
    .evt_sts(evt_sts), .eos_bit(eos_bit));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_sci(input logic [N-1:0] s, input logic [1:0] r);
    if (|(s & evt_en & evt_route)) return 3'b001 << r;
    return 3'b000;
  endfunction

  task automatic model_edge();
    logic smi_p;
    smi_p = |(m_sts & evt_en & ~evt_route);
    case (m_st)
      0: if (smi_p) m_st = 1;
      1: if (m_eos) begin m_st = 2; m_eos = 1'b0; m_cnt = 1; end
         else if (eos_set) m_eos = 1'b1;
      default: if (m_cnt == GAP) m_st = smi_p ? 1 : 0; else m_cnt++;
    endcase
    m_sts = (m_sts & ~sts_clr) | evt_pulse;
    if (cfg_wr && cfg_irq != 2'd3) m_route = cfg_irq;
  endtask

  task automatic compare();
    chk(smi_n === (m_st != 1), "R1/R2/R3/R4/R9 smi_n", smi_n, (m_st != 1));
    chk(evt_sts === m_sts, "R6 evt_sts", evt_sts, m_sts);
    chk(eos_bit === m_eos, "R2/R5 eos_bit", eos_bit, m_eos);
    chk(sci_irq === exp_sci(m_sts, m_route), "R7/R8/R9 sci_irq", sci_irq, exp_sci(m_sts, m_route));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    evt_pulse = '0; sts_clr = '0; eos_set = 1'b0; cfg_wr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'h5eed_1234));
    m_sts = '0; m_st = 0; m_cnt = 0; m_eos = 1'b0; m_route = 2'd0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(smi_n === 1'b1 && sci_irq === 3'b000 && evt_sts === '0 && eos_bit === 1'b0,
        "R10 reset", {smi_n, sci_irq, eos_bit}, 5'b10000);
    rst_n = 1'b1;
    step();

    // R5: EOS while idle is ignored
    eos_set = 1'b1; step(); step();
    chk(eos_bit === 1'b0, "R5 eos idle", eos_bit, 0);

    // R9: SCI-routed event does not lower smi_n; default IRQ 9 (R10)
    evt_en = 8'hFF; evt_route = 8'h0F;
    evt_pulse = 8'h01; step(); step();
    chk(smi_n === 1'b1, "R9 sci event smi_n", smi_n, 1);
    chk(sci_irq === 3'b001, "R10 default irq9", sci_irq, 1);

    // R8: routing codes and ignored code 3
    cfg_irq = 2'd2; cfg_wr = 1'b1; step();
    chk(sci_irq === 3'b100, "R8 irq11", sci_irq, 4);
    cfg_irq = 2'd3; cfg_wr = 1'b1; step();
    chk(sci_irq === 3'b100, "R8 code3 ignored", sci_irq, 4);
    cfg_irq = 2'd1; cfg_wr = 1'b1; step();
    chk(sci_irq === 3'b010, "R8 irq10", sci_irq, 2);

    // R6: set wins over clear in the same cycle, then plain clear
    evt_pulse = 8'h01; sts_clr = 8'h01; step();
    chk(evt_sts[0] === 1'b1, "R6 set over clear", evt_sts[0], 1);
    sts_clr = 8'h01; step();
    chk(sci_irq === 3'b000, "R7 level drops", sci_irq, 0);

    // R1: SMI event lowers smi_n one clock after status shows
    evt_pulse = 8'h10; step();
    chk(smi_n === 1'b1, "R1 status first", smi_n, 1);
    step();
    chk(smi_n === 1'b0, "R1 smi asserted", smi_n, 0);
    sts_clr = 8'h10; repeat (3) step();
    chk(smi_n === 1'b0, "R2 held without eos", smi_n, 0);

    // R3/R4: event arrives, EOS, gap of exactly GAP with work pending
    eos_set = 1'b1; step();
    chk(eos_bit === 1'b1, "R2 eos reads 1", eos_bit, 1);
    step();
    chk(smi_n === 1'b1 && eos_bit === 1'b0, "R2 release", {smi_n, eos_bit}, 2);
    evt_pulse = 8'h20;
    hi = 1;
    while (smi_n && hi < 20) begin step(); if (smi_n) hi++; end
    chk(hi == GAP, "R3 gap length", hi, GAP);
    chk(smi_n === 1'b0, "R4 reassert after gap", smi_n, 0);
    sts_clr = 8'h20; eos_set = 1'b1; step(); step();
    repeat (6) step();

    // random phase
    for (int blk = 0; blk < 300; blk++) begin
      sts_clr = '1; step();
      repeat (GAP + 2) begin eos_set = 1'b1; step(); end
      sts_clr = '1; step();
      evt_en = N'($urandom); evt_route = N'($urandom);
      for (int c = 0; c < 40; c++) begin
        if ($urandom % 3 == 0) evt_pulse = N'($urandom) & N'($urandom);
        if ($urandom % 5 == 0) sts_clr = N'($urandom);
        if ($urandom % 6 == 0) eos_set = 1'b1;
        if ($urandom % 15 == 0) begin cfg_wr = 1'b1; cfg_irq = 2'($urandom); end
        step();
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule